// File: doc/BRIEF.md
# Capture/Compare Timer with Flag Status

This block is a four-channel timer. A free-running up-counter feeds four general registers. A static mode input sets each channel to either input capture or output compare. In capture mode, the chosen edge of a channel's pin copies the counter into that channel's register. In compare mode, the channel signals an event whenever the counter equals its register.

Every channel event and every counter wrap sets a bit in an 8-bit status register. Hardware sets these bits. Software can clear a bit only under a guarded rule: it must first read the bit as 1, then write 0 to it. A transfer-acknowledge input can also clear the flag of the channel that started the transfer. An interrupt request combines the flags with a per-flag enable register.

The register bus uses separate read and write strobes, a 3-bit address and combinational read data. Bus data is `CNT_W` bits wide, and `CNT_W` must be at least 8.

Top module: `cct_timer`

## Requirements
- R1: The counter is `CNT_W` bits wide and counts up by one every cycle. A bus write to address 2 loads it, and it reads back at address 2. When it steps from all-ones to zero without a write, it sets the overflow flag, which is status bit 7.
- R2: In capture mode (`cap_mode[c]`=1), a detected edge on pin c copies the counter into general register c and sets status bit c. The pin passes through two synchronizer flops before edge detection. Example: the pin rises in the same cycle as a counter write of C. The register then captures C+1, and the value is visible four cycles after the pin change.
- R3: `cap_fall[c]`=0 selects rising edges and 1 selects falling edges. An edge of the other polarity leaves the register and the flag unchanged.
- R4: In compare mode (`cap_mode[c]`=0), status bit c sets when the counter equals general register c. General register c is written and read at address 4+c.
- R5: The status register is at address 0. Bits 0–3 are the flags of channels A–D, and bit 7 is overflow. Bits 4–6 always read 1, whatever is written. The reset value is 70h.
- R6: Writing 0 to a status bit clears it only if that bit read as 1 in a status read since the last status write. Writing 1 never changes a bit.
- R7: Every status write disarms all bits. A later 0-write needs a fresh read before it can clear anything.
- R8: When a hardware set and a clear land on the same flag in the same cycle, the flag ends up set.
- R9: A one-cycle `xfer_ack` clears only the flag of channel `xfer_src` (0=A … 3=D).
- R10: The enable register is at address 1 and uses the same bit positions as the status register. `irq` is high exactly when some flag and its enable bit are both 1.
- R11: After reset, the general registers and the enable register read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status bits) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data (combinational) |
| cap_pin | input | 4 | Asynchronous capture pins, one per channel |
| cap_mode | input | 4 | Per channel: 1 capture, 0 compare |
| cap_fall | input | 4 | Per channel: 1 falling edge, 0 rising edge |
| xfer_ack | input | 1 | Transfer-acknowledge pulse |
| xfer_src | input | 2 | Channel whose interrupt started the transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with `CNT_W`=8, so the counter wraps every 256 cycles. This brings overflow, and compare matches after a counter reload, within a few dozen cycles. It also lets the bench compute the captured counter value exactly from cycle counts. The capture and clear timings are arranged so that a hardware set and a software clear fall on the same clock edge. The bench also exercises the read-then-write clear rule with and without the intervening read.

// File: rtl/cct_pkg.sv
// Package cct_pkg
// Shared constants of the capture/compare timer: the register addresses and
// the status byte layout. Assumes four channels, which the status layout fixes.
package cct_pkg;
    localparam int NUM_CH   = 4;
    localparam int STAT_W   = 8;
    localparam int OVF_BIT  = 7;
    localparam logic [STAT_W-1:0] USED_MASK = 8'h8F;
    localparam logic [2:0] ADR_STAT = 3'd0;
    localparam logic [2:0] ADR_IEN  = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;
    localparam logic       ADR_GR_HI = 1'b1; // addr[2]=1 selects GR[addr[1:0]]
endpackage

// File: rtl/cct_edge_sync.sv
// Module cct_edge_sync
// Synchronizes one asynchronous capture pin through two flops. It then
// raises edge_o for one cycle on the selected polarity.
// Assumes fall_sel_i is quasi-static.
module cct_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic s1_q, s2_q, prev_q;

    // two-flop synchronizer plus history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // polarity-selected edge pulse
    always_comb edge_o = fall_sel_i ? (prev_q & ~s2_q) : (~prev_q & s2_q);

    // R3
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || (fall_sel_i != $past(fall_sel_i))));
endmodule

// File: rtl/cct_channel.sv
// Module cct_channel
// One general register. In capture mode it loads the counter on an edge.
// In compare mode it reports equality with the counter.
// A capture takes priority over a bus write in the same cycle.
module cct_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_mode_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] gr_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] gr_q;

    // general register: capture wins over software write
    always_ff @(posedge clk) begin
        if (!rst_n)                    gr_q <= '0;
        else if (cap_mode_i && edge_i) gr_q <= cnt_i;
        else if (wr_i)                 gr_q <= wdata_i;
    end

    // channel event: capture edge or compare match
    always_comb hit_o = cap_mode_i ? edge_i : (cnt_i == gr_q);
    assign gr_o = gr_q;

    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && edge_i) |=> (gr_q == $past(cnt_i)));
endmodule

// File: rtl/cct_status.sv
// Module cct_status
// Status flags with hardware set and guarded software clear.
// A status read arms the flags that read as 1. A status write clears the
// armed flags written 0, then disarms all of them.
// Acknowledge clears arrive as a mask. A set always beats a clear.
module cct_status
    import cct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] ack_clr_i,
    output logic [STAT_W-1:0] flags_o
);
    logic [STAT_W-1:0] flag_q, arm_q, sw_clr, keep_m;

    // software clear mask: armed bits written as 0
    always_comb sw_clr = wr_i ? (arm_q & ~wdata_i) : '0;

    // flag storage, set has priority over any clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ((flag_q & ~(sw_clr | ack_clr_i)) | set_i) & USED_MASK;
    end

    // arm bits: read arms ones, any status write disarms
    always_ff @(posedge clk) begin
        if (!rst_n)    arm_q <= '0;
        else if (wr_i) arm_q <= '0;
        else if (rd_i) arm_q <= (arm_q | flag_q) & USED_MASK;
    end

    // unassigned bits present as ones
    always_comb flags_o = flag_q | ~USED_MASK;
    always_comb keep_m  = flag_q & ~arm_q & ~ack_clr_i;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    // R6
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_m != '0) |=> ((flag_q & $past(keep_m)) == $past(keep_m)));
    // R7
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (arm_q == '0));
endmodule

// File: rtl/cct_timer.sv
// Module cct_timer (top)
// Free-running counter, four capture/compare channels, status flags,
// interrupt enable register and interrupt output.
// Assumes CNT_W >= 8, so that the status byte fits the bus.
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [3:0]       cap_pin,
    input  logic [3:0]       cap_mode,
    input  logic [3:0]       cap_fall,
    input  logic             xfer_ack,
    input  logic [1:0]       xfer_src,
    output logic             irq
);
    logic [CNT_W-1:0]  cnt_q;
    logic [STAT_W-1:0] ien_q, flags, set_vec, ack_clr;
    logic [CNT_W-1:0]  gr [NUM_CH];
    logic [NUM_CH-1:0] edge_v, hit_v, gr_wr;
    logic              cnt_wr, ovf_evt, stat_rd, stat_wr;

    always_comb begin
        cnt_wr  = bus_wr && (bus_addr == ADR_CNT);
        stat_wr = bus_wr && (bus_addr == ADR_STAT);
        stat_rd = bus_rd && (bus_addr == ADR_STAT);
        ovf_evt = (cnt_q == {CNT_W{1'b1}}) && !cnt_wr;
    end

    // free-running counter with software load
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= bus_wdata;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                                ien_q <= '0;
        else if (bus_wr && bus_addr == ADR_IEN)    ien_q <= bus_wdata[STAT_W-1:0] & USED_MASK;
    end

    // per-channel synchronizer and general register
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign gr_wr[c] = bus_wr && (bus_addr[2] == ADR_GR_HI) && (bus_addr[1:0] == 2'(c));
        cct_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(cap_pin[c]),
            .fall_sel_i(cap_fall[c]), .edge_o(edge_v[c])
        );
        cct_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .cap_mode_i(cap_mode[c]), .edge_i(edge_v[c]),
            .cnt_i(cnt_q), .wr_i(gr_wr[c]), .wdata_i(bus_wdata),
            .gr_o(gr[c]), .hit_o(hit_v[c])
        );
    end

    // event and acknowledge vectors in status layout
    always_comb begin
        set_vec = {ovf_evt, 3'b000, hit_v};
        ack_clr = xfer_ack ? (STAT_W'(1) << xfer_src) : '0;
    end

    cct_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .rd_i(stat_rd), .wr_i(stat_wr),
        .wdata_i(bus_wdata[STAT_W-1:0]), .ack_clr_i(ack_clr), .flags_o(flags)
    );

    // read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[2] == ADR_GR_HI)   bus_rdata = gr[bus_addr[1:0]];
        else if (bus_addr == ADR_STAT)  bus_rdata = CNT_W'(flags);
        else if (bus_addr == ADR_IEN)   bus_rdata = CNT_W'(ien_q);
        else if (bus_addr == ADR_CNT)   bus_rdata = cnt_q;
    end

    // interrupt request
    always_comb irq = |(flags & ien_q & USED_MASK);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R1
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flags[OVF_BIT]);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !hit_v[xfer_src]) |=> !flags[$past(xfer_src)]);
    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

// File: tb/test_cct_timer.sv
module test_cct_timer;
    localparam int CLK_P = 10;
    localparam int CW    = 8;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [CW-1:0] bus_wdata = 0, bus_rdata;
    logic [3:0] cap_pin = 0, cap_mode = 4'hF, cap_fall = 0;
    logic xfer_ack = 0;
    logic [1:0] xfer_src = 0;
    logic irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cct_timer #(.CNT_W(CW)) i_cct_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cap_mode(cap_mode),
        .cap_fall(cap_fall), .xfer_ack(xfer_ack), .xfer_src(xfer_src), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] v);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic clear_all();
        logic [CW-1:0] v;
        rd(3'd0, v); wr(3'd0, 8'h70);
    endtask

    task automatic pin_set(input int c, input logic val);
        @(negedge clk); cap_pin[c] = val;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        #1;
        chk("R11 irq after reset", 16'(irq), 16'h0);
        rd(3'd0, v); chk("R5 status reset value", 16'(v), 16'h70);
        rd(3'd4, v); chk("R11 GR A reset", 16'(v), 16'h0);
        rd(3'd1, v); chk("R11 enable reset", 16'(v), 16'h0);
    endtask

    task automatic t_capture();
        logic [CW-1:0] v;
        clear_all();
        @(negedge clk); bus_wr = 1; bus_addr = 3'd2; bus_wdata = 8'h40; cap_pin[1] = 1;
        @(negedge clk); bus_wr = 0;
        repeat (4) @(negedge clk);
        rd(3'd5, v); chk("R2 captured value", 16'(v), 16'h41);
        rd(3'd0, v); chk("R2 capture flag B", 16'(v[1]), 16'h1);
        pin_set(1, 0);
        clear_all();
    endtask

    task automatic t_edge_sel();
        logic [CW-1:0] v;
        clear_all();
        cap_fall[2] = 1;
        pin_set(2, 1);
        rd(3'd0, v); chk("R3 rising ignored on falling select", 16'(v[2]), 16'h0);
        pin_set(2, 0);
        rd(3'd0, v); chk("R3 falling edge sets flag C", 16'(v[2]), 16'h1);
        cap_fall[2] = 0;
        clear_all();
    endtask

    task automatic t_compare();
        logic [CW-1:0] v;
        wr(3'd7, 8'd100);
        wr(3'd2, 8'd80);
        clear_all();
        @(negedge clk); cap_mode[3] = 0;
        rd(3'd0, v); chk("R4 no match yet", 16'(v[3]), 16'h0);
        repeat (25) @(negedge clk);
        rd(3'd0, v); chk("R4 compare match flag D", 16'(v[3]), 16'h1);
        @(negedge clk); cap_mode[3] = 1;
        clear_all();
    endtask

    task automatic t_clear_rules();
        logic [CW-1:0] v;
        wr(3'd2, 8'h00);
        clear_all();
        pin_set(0, 1); pin_set(0, 0);
        wr(3'd0, 8'h70);
        rd(3'd0, v); chk("R6 zero without read keeps flag", 16'(v[0]), 16'h1);
        wr(3'd0, 8'hFF);
        rd(3'd0, v); chk("R6 write one keeps flag", 16'(v[0]), 16'h1);
        rd(3'd0, v); wr(3'd0, 8'h70);
        rd(3'd0, v); chk("R6 read then zero clears", 16'(v[0]), 16'h0);
        chk("R5 unused bits read one", 16'(v[6:4]), 16'h7);
    endtask

    task automatic t_disarm();
        logic [CW-1:0] v;
        clear_all();
        pin_set(2, 1); pin_set(2, 0);
        rd(3'd0, v);
        wr(3'd0, 8'hFF);
        wr(3'd0, 8'h70);
        rd(3'd0, v); chk("R7 write disarms", 16'(v[2]), 16'h1);
        wr(3'd0, 8'h70);
        rd(3'd0, v); chk("R7 rearmed clear", 16'(v[2]), 16'h0);
    endtask

    task automatic t_set_wins();
        logic [CW-1:0] v;
        clear_all();
        pin_set(0, 1); pin_set(0, 0);
        rd(3'd0, v);
        @(negedge clk); cap_pin[0] = 1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h70;
        @(negedge clk); bus_wr = 0;
        repeat (2) @(negedge clk);
        rd(3'd0, v); chk("R8 set beats clear", 16'(v[0]), 16'h1);
        pin_set(0, 0);
        clear_all();
    endtask

    task automatic t_ack();
        logic [CW-1:0] v;
        clear_all();
        pin_set(0, 1); pin_set(0, 0);
        pin_set(1, 1); pin_set(1, 0);
        @(negedge clk); xfer_ack = 1; xfer_src = 2'd1;
        @(negedge clk); xfer_ack = 0;
        rd(3'd0, v); chk("R9 ack clears only B", 16'(v[3:0]), 16'h1);
        clear_all();
    endtask

    task automatic t_irq();
        logic [CW-1:0] v;
        clear_all();
        wr(3'd1, 8'h01);
        #1 chk("R10 irq low with no flag", 16'(irq), 16'h0);
        pin_set(0, 1); pin_set(0, 0);
        #1 chk("R10 irq on enabled flag", 16'(irq), 16'h1);
        wr(3'd1, 8'h02);
        #1 chk("R10 irq masked", 16'(irq), 16'h0);
        wr(3'd1, 8'h00);
        clear_all();
    endtask

    task automatic t_overflow();
        logic [CW-1:0] v;
        clear_all();
        wr(3'd2, 8'hFC);
        repeat (6) @(negedge clk);
        rd(3'd0, v); chk("R1 overflow flag", 16'(v[7]), 16'h1);
        rd(3'd2, v); chk("R1 counter wrapped low", 16'(v < 8'h20), 16'h1);
        wr(3'd0, 8'h70);
        rd(3'd0, v); chk("R1 overflow cleared", 16'(v[7]), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_capture();
        t_edge_sel();
        t_compare();
        t_clear_rules();
        t_disarm();
        t_set_wins();
        t_ack();
        t_irq();
        t_overflow();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule